// File: doc/BRIEF.md
# Warp Mesh Traversal Sequencer

This block walks a rectangular grid of texture-coordinate vertices stored in memory. For every grid cell it produces one destination quad. A quad carries the texture coordinates of its four corners and the screen rectangle that the cell covers. Each mesh row in memory has a fixed pitch of 128 vertex entries, however many columns are active. Each entry is 8 bytes: a 32-bit horizontal coordinate followed by a 32-bit vertical coordinate, each stored most-significant byte first.

A start pulse latches the configuration. The configuration is the entry base address, the indices of the last vertex column and last vertex row, the cell width and height in destination pixels, and the destination offsets. The sequencer then reads the four corners of each cell through a simple read port with a fixed one-cycle latency. It presents the finished quad on a valid/ready stream and waits for that quad to be accepted before it fetches the next cell. When the last cell has been accepted, it pulses done.

A downstream rasteriser or texture sampler consumes the quads. Sampling, filling and blending are handled elsewhere.

Top module: `mesh_walker`

## Requirements
- R1: While reset is held and after its release, busy_o, done_o, err_o, mem_req_o and quad_valid_o are all 0.
- R2: After an accepted start with last-column index H and last-row index V (both non-zero, base aligned), exactly H*V quads are emitted. Rows run from 0 to V-1 in the outer order and columns from 0 to H-1 in the inner order.
- R3: Corner slot k of quad_u_o/quad_v_o (bits [32k+31:32k]) holds, for cell (x, y), the vertex at (x,y), (x+1,y), (x+1,y+1), (x,y+1) for k = 0, 1, 2, 3. Vertex (i, j) is read at byte address base + 8*(128*j + i).
- R4: The read data lane for byte offset b of the 8-byte entry is mem_rdata_i[8b+7:8b]. The horizontal coordinate is bytes 0..3 and the vertical coordinate is bytes 4..7, with byte 0 (or byte 4) the most significant byte on the output.
- R5: The rectangle of cell (x, y) is x0 = xoff + x*sqw, x1 = x0 + sqw, y0 = yoff + y*sqh, y1 = y0 + sqh, all taken modulo 2^16.
- R6: A start with H = 0 or V = 0 emits no quad and issues no read. done_o pulses in the cycle after the start.
- R7: A start with a base address whose low three bits are not all zero sets err_o, emits no quad, issues no read and pulses done_o in the cycle after the start. err_o stays set until the next accepted start with an aligned base.
- R8: While quad_valid_o is 1 and quad_ready_i is 0, quad_valid_o and every quad output field hold their values into the next cycle.
- R9: busy_o is 1 from the cycle after an accepted start until done_o pulses. A start pulse, and any change on the configuration inputs, during that time has no effect on the quads produced.
- R10: done_o is a one-cycle pulse. busy_o and quad_valid_o are 0 in that cycle, and the pulse comes in the cycle after the last quad is accepted.
- R11: mem_req_o is high for exactly the 4 cycles after the start or accept edge. quad_valid_o rises 6 cycles after that edge, and no read is issued while quad_valid_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only when idle |
| cfg_base_i | input | 32 | Byte address of vertex (0,0) |
| cfg_hlast_i | input | 7 | Index of last vertex column |
| cfg_vlast_i | input | 7 | Index of last vertex row |
| cfg_xoff_i | input | 16 | Horizontal destination offset |
| cfg_yoff_i | input | 16 | Vertical destination offset |
| cfg_sqw_i | input | 16 | Cell width in destination pixels |
| cfg_sqh_i | input | 16 | Cell height in destination pixels |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read byte address, 8-byte aligned |
| mem_rdata_i | input | 64 | Read data, one cycle after request |
| quad_valid_o | output | 1 | Quad available |
| quad_ready_i | input | 1 | Quad accepted when high with valid |
| quad_u_o | output | 128 | Four horizontal texture coordinates |
| quad_v_o | output | 128 | Four vertical texture coordinates |
| quad_x0_o | output | 16 | Rectangle left edge |
| quad_y0_o | output | 16 | Rectangle top edge |
| quad_x1_o | output | 16 | Rectangle right edge |
| quad_y1_o | output | 16 | Rectangle bottom edge |
| busy_o | output | 1 | Traversal in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last start had a misaligned base |

## Verification
The assertions assume that the read port always answers one cycle after a request, since the block has no read handshake. The bench's memory model returns data on the clock after each request and never delays it. The assertions also assume that the last indices never exceed 127, which the 7-bit configuration ports enforce. The stimulus varies the ready pattern between always-ready and two-cycle stalls. It pokes start and the configuration inputs mid-run, and it covers empty grids, a misaligned base, a full 127-column row and offset wrap-around.

// File: rtl/mesh_walker_pkg.sv
// Shared types for the mesh traversal sequencer.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package mesh_walker_pkg;

    // Sequencer states: idle, corner fetch, last-read capture, quad output, finish pulse
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_CAPT  = 3'd2,
        ST_OUT   = 3'd3,
        ST_FIN   = 3'd4
    } walk_state_e;

    localparam int CORNERS = 4;

endpackage

// File: rtl/mesh_corner_addr.sv
// Computes the byte address of one corner of the current mesh cell.
// Corner 0..3 maps to (x,y), (x+1,y), (x+1,y+1), (x,y+1).
// Assumes: the row pitch is 2**IDX_W entries and the entry size is 2**ENT_LG bytes.
module mesh_corner_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    parameter int ENT_LG = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  cx_i,
    input  logic [IDX_W-1:0]  cy_i,
    input  logic [1:0]        corner_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic              dx;
    logic              dy;
    logic [IDX_W:0]    xx;
    logic [IDX_W:0]    yy;
    logic [ADDR_W-1:0] entry;

    // Corner offsets and entry index arithmetic
    always_comb begin
        dx     = (corner_i == 2'd1) || (corner_i == 2'd2);
        dy     = corner_i[1];
        xx     = (IDX_W+1)'(cx_i) + (IDX_W+1)'(dx);
        yy     = (IDX_W+1)'(cy_i) + (IDX_W+1)'(dy);
        entry  = (ADDR_W'(yy) << IDX_W) + ADDR_W'(xx);
        addr_o = base_i + (entry << ENT_LG);
    end
endmodule

// File: rtl/mesh_vertex_unpack.sv
// Splits one raw vertex entry into its two coordinates, reversing byte order.
// Byte lane b of the entry sits at raw_i[8b+7:8b]; the lowest-addressed byte
// of each coordinate is its most significant byte.
// Assumes: TC_W is a multiple of 8.
module mesh_vertex_unpack #(
    parameter int TC_W = 32
) (
    input  logic [2*TC_W-1:0] raw_i,
    output logic [TC_W-1:0]   u_o,
    output logic [TC_W-1:0]   v_o
);
    localparam int NBYTES = TC_W / 8;

    // One lane swap per byte of each coordinate
    for (genvar j = 0; j < NBYTES; j++) begin : g_lane
        assign u_o[TC_W-1-8*j -: 8] = raw_i[8*j +: 8];
        assign v_o[TC_W-1-8*j -: 8] = raw_i[TC_W+8*j +: 8];
    end
endmodule

// File: rtl/mesh_dest_rect.sv
// Destination rectangle of a mesh cell: index times cell size plus offset.
// Assumes: COORD_W > IDX_W; results wrap modulo 2**COORD_W.
module mesh_dest_rect #(
    parameter int IDX_W   = 7,
    parameter int COORD_W = 16
) (
    input  logic [IDX_W-1:0]   cx_i,
    input  logic [IDX_W-1:0]   cy_i,
    input  logic [COORD_W-1:0] xoff_i,
    input  logic [COORD_W-1:0] yoff_i,
    input  logic [COORD_W-1:0] sqw_i,
    input  logic [COORD_W-1:0] sqh_i,
    output logic [COORD_W-1:0] x0_o,
    output logic [COORD_W-1:0] y0_o,
    output logic [COORD_W-1:0] x1_o,
    output logic [COORD_W-1:0] y1_o
);
    logic [COORD_W-1:0] cx_ext;
    logic [COORD_W-1:0] cy_ext;

    // Scaled index plus offset, then far edge one cell further
    always_comb begin
        cx_ext = COORD_W'(cx_i);
        cy_ext = COORD_W'(cy_i);
        x0_o   = xoff_i + cx_ext * sqw_i;
        y0_o   = yoff_i + cy_ext * sqh_i;
        x1_o   = x0_o + sqw_i;
        y1_o   = y0_o + sqh_i;
    end
endmodule

// File: rtl/mesh_walker.sv
// Mesh traversal sequencer top level.
// Walks cells row by row, fetches four corners per cell through a read port
// of fixed one-cycle latency, and offers each finished quad on a valid/ready
// stream. The fetch of the next cell waits until the current quad is taken.
// Assumes: memory answers every request exactly one cycle later.
module mesh_walker
    import mesh_walker_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 7,
    parameter int COORD_W = 16,
    parameter int TC_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    cfg_base_i,
    input  logic [IDX_W-1:0]     cfg_hlast_i,
    input  logic [IDX_W-1:0]     cfg_vlast_i,
    input  logic [COORD_W-1:0]   cfg_xoff_i,
    input  logic [COORD_W-1:0]   cfg_yoff_i,
    input  logic [COORD_W-1:0]   cfg_sqw_i,
    input  logic [COORD_W-1:0]   cfg_sqh_i,
    output logic                 mem_req_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    input  logic [2*TC_W-1:0]    mem_rdata_i,
    output logic                 quad_valid_o,
    input  logic                 quad_ready_i,
    output logic [4*TC_W-1:0]    quad_u_o,
    output logic [4*TC_W-1:0]    quad_v_o,
    output logic [COORD_W-1:0]   quad_x0_o,
    output logic [COORD_W-1:0]   quad_y0_o,
    output logic [COORD_W-1:0]   quad_x1_o,
    output logic [COORD_W-1:0]   quad_y1_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 err_o
);
    localparam int ENT_BYTES = 2 * TC_W / 8;
    localparam int ENT_LG    = $clog2(ENT_BYTES);

    walk_state_e                  state_q;
    logic [ADDR_W-1:0]            base_q;
    logic [IDX_W-1:0]             hlast_q;
    logic [IDX_W-1:0]             vlast_q;
    logic [COORD_W-1:0]           xoff_q;
    logic [COORD_W-1:0]           yoff_q;
    logic [COORD_W-1:0]           sqw_q;
    logic [COORD_W-1:0]           sqh_q;
    logic [IDX_W-1:0]             cx_q;
    logic [IDX_W-1:0]             cy_q;
    logic [1:0]                   k_q;
    logic                         pend_v_q;
    logic [1:0]                   pend_k_q;
    logic [CORNERS-1:0][TC_W-1:0] u_q;
    logic [CORNERS-1:0][TC_W-1:0] v_q;
    logic                         err_q;

    logic                         start_misal;
    logic                         start_empty;
    logic                         last_cell;
    logic                         last_col;
    logic [TC_W-1:0]              rd_u;
    logic [TC_W-1:0]              rd_v;

    // Corner address for the read currently issued
    mesh_corner_addr #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .ENT_LG (ENT_LG)
    ) u_addr (
        .base_i   (base_q),
        .cx_i     (cx_q),
        .cy_i     (cy_q),
        .corner_i (k_q),
        .addr_o   (mem_addr_o)
    );

    // Byte-order conversion of returning read data
    mesh_vertex_unpack #(
        .TC_W (TC_W)
    ) u_unpack (
        .raw_i (mem_rdata_i),
        .u_o   (rd_u),
        .v_o   (rd_v)
    );

    // Destination rectangle of the current cell
    mesh_dest_rect #(
        .IDX_W   (IDX_W),
        .COORD_W (COORD_W)
    ) u_rect (
        .cx_i   (cx_q),
        .cy_i   (cy_q),
        .xoff_i (xoff_q),
        .yoff_i (yoff_q),
        .sqw_i  (sqw_q),
        .sqh_i  (sqh_q),
        .x0_o   (quad_x0_o),
        .y0_o   (quad_y0_o),
        .x1_o   (quad_x1_o),
        .y1_o   (quad_y1_o)
    );

    // Start qualification and end-of-grid detection
    always_comb begin
        start_misal = |cfg_base_i[ENT_LG-1:0];
        start_empty = (cfg_hlast_i == '0) || (cfg_vlast_i == '0);
        last_col    = (cx_q == hlast_q - IDX_W'(1));
        last_cell   = last_col && (cy_q == vlast_q - IDX_W'(1));
    end

    // Read-return tracking: remember which corner each request fills
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q <= 1'b0;
            pend_k_q <= '0;
            u_q      <= '0;
            v_q      <= '0;
        end else begin
            pend_v_q <= (state_q == ST_FETCH);
            pend_k_q <= k_q;
            if (pend_v_q) begin
                u_q[pend_k_q] <= rd_u;
                v_q[pend_k_q] <= rd_v;
            end
        end
    end

    // Traversal state machine with configuration latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            hlast_q <= '0;
            vlast_q <= '0;
            xoff_q  <= '0;
            yoff_q  <= '0;
            sqw_q   <= '0;
            sqh_q   <= '0;
            cx_q    <= '0;
            cy_q    <= '0;
            k_q     <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        base_q  <= cfg_base_i;
                        hlast_q <= cfg_hlast_i;
                        vlast_q <= cfg_vlast_i;
                        xoff_q  <= cfg_xoff_i;
                        yoff_q  <= cfg_yoff_i;
                        sqw_q   <= cfg_sqw_i;
                        sqh_q   <= cfg_sqh_i;
                        cx_q    <= '0;
                        cy_q    <= '0;
                        k_q     <= '0;
                        err_q   <= start_misal;
                        state_q <= (start_misal || start_empty) ? ST_FIN : ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    k_q <= k_q + 2'd1;
                    if (k_q == 2'd3) begin
                        state_q <= ST_CAPT;
                    end
                end
                ST_CAPT: begin
                    state_q <= ST_OUT;
                end
                ST_OUT: begin
                    if (quad_ready_i) begin
                        if (last_cell) begin
                            state_q <= ST_FIN;
                        end else begin
                            if (last_col) begin
                                cx_q <= '0;
                                cy_q <= cy_q + IDX_W'(1);
                            end else begin
                                cx_q <= cx_q + IDX_W'(1);
                            end
                            k_q     <= '0;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Output decode from state
    always_comb begin
        mem_req_o    = (state_q == ST_FETCH);
        quad_valid_o = (state_q == ST_OUT);
        done_o       = (state_q == ST_FIN);
        busy_o       = (state_q == ST_FETCH) || (state_q == ST_CAPT) || (state_q == ST_OUT);
        err_o        = err_q;
        quad_u_o     = u_q;
        quad_v_o     = v_q;
    end
endmodule

// File: rtl/mesh_walker_chk.sv
// Protocol checker for the mesh traversal sequencer, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module mesh_walker_chk #(
    parameter int ADDR_W  = 32,
    parameter int COORD_W = 16,
    parameter int TC_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req_o,
    input logic [ADDR_W-1:0]  mem_addr_o,
    input logic               quad_valid_o,
    input logic               quad_ready_i,
    input logic [4*TC_W-1:0]  quad_u_o,
    input logic [4*TC_W-1:0]  quad_v_o,
    input logic [COORD_W-1:0] quad_x0_o,
    input logic [COORD_W-1:0] quad_y0_o,
    input logic [COORD_W-1:0] quad_x1_o,
    input logic [COORD_W-1:0] quad_y1_o,
    input logic               busy_o,
    input logic               done_o,
    input logic               err_o
);
    localparam int ENT_LG = $clog2(2 * TC_W / 8);

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        quad_valid_o && !quad_ready_i |=> quad_valid_o && $stable(quad_u_o) && $stable(quad_v_o)
        && $stable(quad_x0_o) && $stable(quad_y0_o) && $stable(quad_x1_o) && $stable(quad_y1_o)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !quad_valid_o); // R10

    AST_NO_READ_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        quad_valid_o |-> !mem_req_o); // R11

    AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[ENT_LG-1:0] == '0)); // R3

    AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_req_o && !quad_valid_o); // R7

    AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o); // R9
endmodule

bind mesh_walker mesh_walker_chk #(
    .ADDR_W  (ADDR_W),
    .COORD_W (COORD_W),
    .TC_W    (TC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .quad_valid_o (quad_valid_o),
    .quad_ready_i (quad_ready_i),
    .quad_u_o     (quad_u_o),
    .quad_v_o     (quad_v_o),
    .quad_x0_o    (quad_x0_o),
    .quad_y0_o    (quad_y0_o),
    .quad_x1_o    (quad_x1_o),
    .quad_y1_o    (quad_y1_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/mesh_walker_tb.sv
// Self-checking bench: behavioural expected-quad queue and a memory model,
// compared against the design at every falling clock edge.
module mesh_walker_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  cfg_base_i = '0;
    logic [6:0]   cfg_hlast_i = '0;
    logic [6:0]   cfg_vlast_i = '0;
    logic [15:0]  cfg_xoff_i = '0;
    logic [15:0]  cfg_yoff_i = '0;
    logic [15:0]  cfg_sqw_i = '0;
    logic [15:0]  cfg_sqh_i = '0;
    logic         mem_req_o;
    logic [31:0]  mem_addr_o;
    logic [63:0]  mem_rdata_i = '0;
    logic         quad_valid_o;
    logic         quad_ready_i = 1'b0;
    logic [127:0] quad_u_o;
    logic [127:0] quad_v_o;
    logic [15:0]  quad_x0_o, quad_y0_o, quad_x1_o, quad_y1_o;
    logic         busy_o, done_o, err_o;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [127:0] u;
        logic [127:0] v;
        logic [63:0]  r;
    } quad_t;

    always #5 clk = ~clk;

    mesh_walker u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .cfg_base_i (cfg_base_i), .cfg_hlast_i (cfg_hlast_i), .cfg_vlast_i (cfg_vlast_i),
        .cfg_xoff_i (cfg_xoff_i), .cfg_yoff_i (cfg_yoff_i),
        .cfg_sqw_i (cfg_sqw_i), .cfg_sqh_i (cfg_sqh_i),
        .mem_req_o (mem_req_o), .mem_addr_o (mem_addr_o), .mem_rdata_i (mem_rdata_i),
        .quad_valid_o (quad_valid_o), .quad_ready_i (quad_ready_i),
        .quad_u_o (quad_u_o), .quad_v_o (quad_v_o),
        .quad_x0_o (quad_x0_o), .quad_y0_o (quad_y0_o),
        .quad_x1_o (quad_x1_o), .quad_y1_o (quad_y1_o),
        .busy_o (busy_o), .done_o (done_o), .err_o (err_o)
    );

    function automatic logic [31:0] tc_u(input logic [31:0] id);
        return (id * 32'h9E37_79B1) ^ 32'h0102_0304;
    endfunction

    function automatic logic [31:0] tc_v(input logic [31:0] id);
        return (id * 32'h85EB_CA6B) + 32'h0A0B_0C0D;
    endfunction

    // Memory image: entry at address a holds tc_u/tc_v of a/8, big-endian bytes
    function automatic logic [63:0] mem_word(input logic [31:0] a);
        logic [63:0] w;
        logic [31:0] u = tc_u(a >> 3);
        logic [31:0] v = tc_v(a >> 3);
        for (int b = 0; b < 4; b++) begin
            w[8*b +: 8]      = u[31-8*b -: 8];
            w[32+8*b +: 8]   = v[31-8*b -: 8];
        end
        return w;
    endfunction

    // One-cycle-latency read port model
    always @(posedge clk) begin
        if (mem_req_o) mem_rdata_i <= mem_word(mem_addr_o);
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_job(input logic [31:0] base, input logic [6:0] hl, input logic [6:0] vl,
                           input logic [15:0] xo, input logic [15:0] yo,
                           input logic [15:0] sw, input logic [15:0] sh, input int mode);
        quad_t exp_q[$];
        quad_t q;
        quad_t hold;
        bit    misal, empty, pv, pr, poked;
        int    g, guard;
        @(negedge clk);
        cfg_base_i = base; cfg_hlast_i = hl; cfg_vlast_i = vl;
        cfg_xoff_i = xo; cfg_yoff_i = yo; cfg_sqw_i = sw; cfg_sqh_i = sh;
        start_i = 1'b1; quad_ready_i = 1'b0;
        misal = (base[2:0] != 3'd0);
        empty = misal || (hl == 0) || (vl == 0);
        if (!empty) begin
            for (int y = 0; y < int'(vl); y++) begin
                for (int x = 0; x < int'(hl); x++) begin
                    for (int c = 0; c < 4; c++) begin
                        int dx = (c == 1 || c == 2) ? 1 : 0;
                        int dy = (c >= 2) ? 1 : 0;
                        logic [31:0] id = (base >> 3) + 32'(128 * (y + dy) + x + dx);
                        q.u[32*c +: 32] = tc_u(id);
                        q.v[32*c +: 32] = tc_v(id);
                    end
                    q.r[63:48] = xo + 16'(x) * sw;
                    q.r[47:32] = yo + 16'(y) * sh;
                    q.r[31:16] = q.r[63:48] + sw;
                    q.r[15:0]  = q.r[47:32] + sh;
                    exp_q.push_back(q);
                end
            end
        end
        if (empty) begin
            @(negedge clk);
            start_i = 1'b0;
            chk("R6 R7 done one cycle after start", 128'(done_o), 128'(1));
            chk("R6 R7 busy low at done", 128'(busy_o), 128'(0));
            chk("R6 R7 no quad", 128'(quad_valid_o), 128'(0));
            chk("R6 R7 no read", 128'(mem_req_o), 128'(0));
            chk("R7 error flag", 128'(err_o), 128'(misal));
            @(negedge clk);
            chk("R10 done is one pulse", 128'(done_o), 128'(0));
            chk("R7 error flag sticky", 128'(err_o), 128'(misal));
            return;
        end
        g = 0; pv = 0; pr = 0; poked = 0; guard = 0; hold = '0;
        while (exp_q.size() != 0 && guard < 20000) begin
            @(negedge clk);
            g++; guard++;
            start_i = 1'b0;
            if (mode == 1 && !poked && g == 3) begin
                // R9: start and configuration changes while busy must not matter
                start_i = 1'b1; poked = 1;
                cfg_base_i = 32'h0000_0100; cfg_hlast_i = 7'd1; cfg_vlast_i = 7'd1;
                cfg_xoff_i = 16'h1234; cfg_sqw_i = 16'd99;
            end
            quad_ready_i = (mode == 0) ? 1'b1 : ((g % 3) == 2);
            chk("R9 busy during run", 128'(busy_o), 128'(1));
            chk("R10 no early done", 128'(done_o), 128'(0));
            chk("R7 error clear on aligned start", 128'(err_o), 128'(0));
            chk("R11 valid timing", 128'(quad_valid_o), 128'(g >= 6));
            chk("R11 read window", 128'(mem_req_o), 128'(g <= 4));
            if (pv && !pr) begin
                chk("R8 u held under stall", quad_u_o, hold.u);
                chk("R8 v held under stall", quad_v_o, hold.v);
                chk("R8 rect held under stall",
                    128'({quad_x0_o, quad_y0_o, quad_x1_o, quad_y1_o}), 128'(hold.r));
            end
            if (quad_valid_o && quad_ready_i) begin
                q = exp_q.pop_front();
                chk("R2 R3 R4 corner u", quad_u_o, q.u);
                chk("R2 R3 R4 corner v", quad_v_o, q.v);
                chk("R2 R5 rectangle",
                    128'({quad_x0_o, quad_y0_o, quad_x1_o, quad_y1_o}), 128'(q.r));
                g = 0;
            end
            pv = quad_valid_o; pr = quad_ready_i;
            hold.u = quad_u_o; hold.v = quad_v_o;
            hold.r = {quad_x0_o, quad_y0_o, quad_x1_o, quad_y1_o};
        end
        if (guard >= 20000) begin
            n_bad++;
            $display("FAIL R2 job stalled actual=%0d expected=0 quads left", exp_q.size());
        end
        @(negedge clk);
        start_i = 1'b0; quad_ready_i = 1'b0;
        chk("R10 done after last accept", 128'(done_o), 128'(1));
        chk("R10 busy low at done", 128'(busy_o), 128'(0));
        chk("R10 valid low at done", 128'(quad_valid_o), 128'(0));
        @(negedge clk);
        chk("R10 done is one pulse", 128'(done_o), 128'(0));
    endtask

    // Watchdog: a hung run counts as a failure and still summarises
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset busy", 128'(busy_o), 128'(0));
        chk("R1 reset done", 128'(done_o), 128'(0));
        chk("R1 reset err", 128'(err_o), 128'(0));
        chk("R1 reset read", 128'(mem_req_o), 128'(0));
        chk("R1 reset valid", 128'(quad_valid_o), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 128'({busy_o, done_o, err_o, mem_req_o, quad_valid_o}), 128'(0));
        run_job(32'h0000_1000, 7'd3, 7'd2, 16'd5, 16'd3, 16'd10, 16'd7, 0);
        run_job(32'h0000_2008, 7'd2, 7'd3, 16'hFFF0, 16'hFFFE, 16'd10, 16'd4, 1);
        run_job(32'h0000_3000, 7'd0, 7'd4, 16'd0, 16'd0, 16'd8, 16'd8, 0);   // R6
        run_job(32'h0000_3000, 7'd5, 7'd0, 16'd0, 16'd0, 16'd8, 16'd8, 0);   // R6
        run_job(32'h0000_1004, 7'd2, 7'd2, 16'd0, 16'd0, 16'd8, 16'd8, 0);   // R7
        run_job(32'h0040_0000, 7'd1, 7'd1, 16'd100, 16'd200, 16'd16, 16'd16, 1);
        run_job(32'h0001_0000, 7'd127, 7'd2, 16'd0, 16'd0, 16'd3, 16'd5, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule